// File: doc/BRIEF.md
# Halfword Transfer Datapath

This block performs halfword moves on a 36-bit word seen as two 18-bit halves: a left (upper) half in bits 35:18 and a right (lower) half in bits 17:0. On a start strobe it takes a source word, a destination word and a 5-bit mode. It picks one half of the source, places it in the chosen half of the destination, and treats the other destination half in one of four ways: keep it, clear it, fill it with ones, or fill it with copies of the moved half's sign bit.

The source half that is moved is normally the same side as the destination half. A swap bit exchanges the source halves first, so a left half can land on the right and the reverse. The result is registered and comes with a one-cycle valid pulse. The result holds its value until the next start. Memory access and register-file selection belong to the surrounding logic.

Top module: `hwt_xfer`

## Requirements
- R1: While `rstN` is low, and after it is released with no start yet, `resValid` is 0 and `result` is all zeros.
- R2: `resValid` is 1 in exactly the cycle after a cycle with `start` high, and 0 otherwise. `result` changes only on a clock edge where `start` is high.
- R3: Mode bit 4 selects the destination half. 1 puts the moved half in bits 17:0, and 0 puts it in bits 35:18.
- R4: Mode bit 1 set moves the source half on the side opposite the destination half. Clear moves the source half on the same side.
- R5: Mode bits 3:2 equal to 00 leave the other destination half equal to the matching half of `dstWord`.
- R6: Mode bits 3:2 equal to 01 make the other destination half all zeros.
- R7: Mode bits 3:2 equal to 10 make the other destination half all ones.
- R8: Mode bits 3:2 equal to 11 make the other half all ones when the moved half's top bit is 1, and all zeros when it is 0. That top bit is bit 35 of `result` for a left destination and bit 17 for a right destination.
- R9: Mode bit 0 has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one transfer with the present inputs |
| srcWord | input | 36 | Word supplying the moved half |
| dstWord | input | 36 | Word supplying the half that is not written |
| mode | input | 5 | Bit 4 destination side, bits 3:2 fill, bit 1 swap, bit 0 unused |
| result | output | 36 | Registered transfer result |
| resValid | output | 1 | One-cycle pulse marking a new result |

## Verification
On every cycle the assertions check the valid timing and the hold of `result` between starts. For left-destination transfers they also check the moved half and the keep, clear and ones fills. Sign extension on both sides, every swap combination, right-side destinations and the mode bit that has no effect are covered by the bench. It runs all 32 mode encodings over source words chosen for their sign bits and compares each cycle against its own model.

// File: rtl/hwt_pkg.sv
package hwt_pkg;
  localparam int MODE_W = 5;
  // mode field bit positions
  localparam int MB_DEST_RT = 4;
  localparam int MB_FILL_HI = 3;
  localparam int MB_FILL_LO = 2;
  localparam int MB_SWAP    = 1;

  typedef enum logic [1:0] {
    FILL_KEEP = 2'b00,
    FILL_ZERO = 2'b01,
    FILL_ONES = 2'b10,
    FILL_SIGN = 2'b11
  } fill_e;

  typedef struct packed {
    logic  load;
    logic  toRight;
    logic  swapSrc;
    fill_e fill;
  } hwt_ctrl_t;
endpackage

// File: rtl/hwt_ctrl.sv
module hwt_ctrl
  import hwt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  output hwt_ctrl_t         ctrl,
  output logic              resValid
);
  logic validQ;

  always_comb begin
    ctrl.load    = start;
    ctrl.toRight = mode[MB_DEST_RT];
    ctrl.swapSrc = mode[MB_SWAP];
    ctrl.fill    = fill_e'({mode[MB_FILL_HI], mode[MB_FILL_LO]});
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= start;
  end

  assign resValid = validQ;
endmodule

// File: rtl/hwt_datapath.sv
module hwt_datapath
  import hwt_pkg::*;
#(
  parameter int HALF_W = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  hwt_ctrl_t           ctrl,
  input  logic [2*HALF_W-1:0] srcWord,
  input  logic [2*HALF_W-1:0] dstWord,
  output logic [2*HALF_W-1:0] result
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int LANES  = 2;

  logic [HALF_W-1:0] srcLane [LANES];
  logic [HALF_W-1:0] dstLane [LANES];
  logic [HALF_W-1:0] nextLane [LANES];
  logic [HALF_W-1:0] movedHalf;
  logic              movedSign;
  logic [WORD_W-1:0] resultQ;

  // lane 0 = right half (low bits), lane 1 = left half (high bits)
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_split
      assign srcLane[g] = srcWord[g*HALF_W +: HALF_W];
      assign dstLane[g] = dstWord[g*HALF_W +: HALF_W];
    end
  endgenerate

  always_comb begin
    // destination lane index is toRight ? 0 : 1; swap picks the opposite source lane
    if (ctrl.toRight ^ ctrl.swapSrc) movedHalf = srcLane[0];
    else                             movedHalf = srcLane[1];
    movedSign = movedHalf[HALF_W-1];
  end

  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      localparam logic IS_RIGHT = (g == 0);
      always_comb begin
        if (ctrl.toRight == IS_RIGHT) begin
          nextLane[g] = movedHalf;
        end else begin
          unique case (ctrl.fill)
            FILL_KEEP: nextLane[g] = dstLane[g];
            FILL_ZERO: nextLane[g] = '0;
            FILL_ONES: nextLane[g] = '1;
            FILL_SIGN: nextLane[g] = {HALF_W{movedSign}};
            default:   nextLane[g] = dstLane[g];
          endcase
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)          resultQ <= '0;
    else if (ctrl.load) resultQ <= {nextLane[1], nextLane[0]};
  end

  assign result = resultQ;
endmodule

// File: rtl/hwt_xfer.sv
module hwt_xfer
  import hwt_pkg::*;
#(
  parameter int HALF_W = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2*HALF_W-1:0] srcWord,
  input  logic [2*HALF_W-1:0] dstWord,
  input  logic [MODE_W-1:0]   mode,
  output logic [2*HALF_W-1:0] result,
  output logic                resValid
);
  hwt_ctrl_t ctrl;

  hwt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .ctrl(ctrl), .resValid(resValid)
  );

  hwt_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .srcWord(srcWord), .dstWord(dstWord), .result(result)
  );
endmodule

// File: rtl/hwt_xfer_chk.sv
module hwt_xfer_chk
  import hwt_pkg::*;
#(
  parameter int HALF_W = 18
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [2*HALF_W-1:0] srcWord,
  input logic [2*HALF_W-1:0] dstWord,
  input logic [MODE_W-1:0]   mode,
  input logic [2*HALF_W-1:0] result,
  input logic                resValid
);
  localparam int WORD_W = 2 * HALF_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!resValid && result == '0));

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resValid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(result));

  // R3
  left_dest_moved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !mode[MB_DEST_RT] && !mode[MB_SWAP]) |=>
      result[WORD_W-1:HALF_W] == $past(srcWord[WORD_W-1:HALF_W]));

  // R5
  keep_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !mode[MB_DEST_RT] && mode[MB_FILL_HI:MB_FILL_LO] == 2'b00) |=>
      result[HALF_W-1:0] == $past(dstWord[HALF_W-1:0]));

  // R6
  zero_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !mode[MB_DEST_RT] && mode[MB_FILL_HI:MB_FILL_LO] == 2'b01) |=>
      result[HALF_W-1:0] == '0);

  // R7
  ones_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !mode[MB_DEST_RT] && mode[MB_FILL_HI:MB_FILL_LO] == 2'b10) |=>
      result[HALF_W-1:0] == '1);
endmodule

bind hwt_xfer hwt_xfer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .srcWord(srcWord),
  .dstWord(dstWord), .mode(mode), .result(result), .resValid(resValid)
);

// File: tb/sim_hwt_xfer.sv
`timescale 1ns/1ps
module sim_hwt_xfer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [35:0] srcWord = '0;
  logic [35:0] dstWord = '0;
  logic [4:0]  mode = '0;
  logic [35:0] result;
  logic        resValid;

  int checks = 0;
  int failures = 0;
  logic running = 1'b0;

  logic [35:0] expResult = '0;
  logic        expValid = 1'b0;
  logic [4:0]  lastMode = '0;

  always #4 clk = ~clk;

  hwt_xfer u0 (
    .clk(clk), .rstN(rstN), .start(start), .srcWord(srcWord),
    .dstWord(dstWord), .mode(mode), .result(result), .resValid(resValid)
  );

  function automatic logic [35:0] refHwt(logic [35:0] s, logic [35:0] d, logic [4:0] m);
    logic [17:0] sL, sR, dL, dR, mv, oth;
    sL = s[35:18]; sR = s[17:0]; dL = d[35:18]; dR = d[17:0];
    if (m[4]) begin mv = m[1] ? sL : sR; oth = dL; end
    else      begin mv = m[1] ? sR : sL; oth = dR; end
    case (m[3:2])
      2'b00: ;
      2'b01: oth = 18'h00000;
      2'b10: oth = 18'h3FFFF;
      default: oth = mv[17] ? 18'h3FFFF : 18'h00000;
    endcase
    return m[4] ? {oth, mv} : {mv, oth};
  endfunction

  function automatic string fillTag(logic [4:0] m);
    case (m[3:2])
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      expValid  <= 1'b0;
      expResult <= '0;
    end else begin
      expValid <= start;
      if (start) begin
        expResult <= refHwt(srcWord, dstWord, mode);
        lastMode  <= mode;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (resValid !== expValid) begin
        failures++;
        $display("FAIL R2 resValid actual=%0b expected=%0b", resValid, expValid);
      end
      checks++;
      if (result !== expResult) begin
        failures++;
        $display("FAIL %s/R3/R4 mode=%o result actual=%o expected=%o",
                 fillTag(lastMode), lastMode, result, expResult);
      end
    end
  end

  task automatic doXfer(input logic [35:0] s, input logic [35:0] d,
                        input logic [4:0] m, output logic [35:0] r);
    @(negedge clk);
    srcWord = s; dstWord = d; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r = result;
    @(negedge clk);
  endtask

  task automatic expectEq(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%o expected=%o", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [35:0] r0, r1;
    logic [35:0] srcSet [4];
    logic [35:0] dstSet [2];
    srcSet[0] = 36'o123456_654321;
    srcSet[1] = 36'o654321_123456;
    srcSet[2] = 36'o400001_000007;
    srcSet[3] = 36'o000003_777770;
    dstSet[0] = 36'o525252_252525;
    dstSet[1] = 36'o070707_707070;

    repeat (3) @(negedge clk);
    // R1: outputs under reset
    expectEq("R1 result in reset", result, 36'o0);
    expectEq("R1 valid in reset", {35'd0, resValid}, 36'o0);
    rstN = 1'b1;
    @(negedge clk);
    expectEq("R1 result after reset", result, 36'o0);
    running = 1'b1;

    // R2..R8: all 32 mode encodings over several source/destination words
    for (int si = 0; si < 4; si++)
      for (int di = 0; di < 2; di++)
        for (int m = 0; m < 32; m++)
          doXfer(srcSet[si], dstSet[di], 5'(m), r0);

    // R3 / R4 directed: cross moves
    doXfer(36'o111111_222222, 36'o0, 5'b10000, r0);
    expectEq("R3 right dest same side", r0, 36'o000000_222222);
    doXfer(36'o111111_222222, 36'o0, 5'b10010, r0);
    expectEq("R4 right dest swapped", r0, 36'o000000_111111);
    doXfer(36'o111111_222222, 36'o777777_777777, 5'b00010, r0);
    expectEq("R4 left dest swapped keep", r0, 36'o222222_777777);
    // R8 directed both signs, both sides
    doXfer(36'o400000_000000, 36'o123456_123456, 5'b01100, r0);
    expectEq("R8 left sign one", r0, 36'o400000_777777);
    doXfer(36'o000000_400000, 36'o123456_123456, 5'b11110, r0);
    expectEq("R8 right swapped sign zero", r0, 36'o000000_000000);
    doXfer(36'o000000_400000, 36'o123456_123456, 5'b11100, r0);
    expectEq("R8 right sign one", r0, 36'o777777_400000);

    // R9: bit 0 of mode has no effect
    for (int m = 0; m < 32; m += 2) begin
      doXfer(36'o765432_012345, 36'o246135_531642, 5'(m), r0);
      doXfer(36'o765432_012345, 36'o246135_531642, 5'(m + 1), r1);
      expectEq("R9 mode bit0 ignored", r1, r0);
    end

    // R2: result held across idle cycles
    doXfer(36'o707070_070707, 36'o0, 5'b00000, r0);
    repeat (4) @(negedge clk);
    expectEq("R2 result held while idle", result, r0);

    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule